// File: doc/BRIEF.md
# Protection Key Permission Checker

This block decides whether a memory access that has already cleared the ordinary paging permission check must still be refused because of its protection key. Two 32-bit key registers are inputs: one governs user pages and one governs supervisor pages. Each register holds sixteen two-bit domains. The 4-bit key of the translated page picks a domain. The page's user/supervisor flag picks the register that domain is read from.

The block does not decode control state for every access. It keeps a 32-bit precomputed gate mask with sixteen two-bit entries, indexed by the access error code bits [4:1]. The mask is rebuilt on every clock from four inputs: the user-page key enable, the supervisor-page key enable, long mode and write-protect. For each access, the selected domain bits are ANDed with the mask entry, and a nonzero result is a key fault. The result is registered and appears one cycle after the request, with a valid strobe. The error code is passed on unchanged, except that bit 5 is set when a key fault is raised.

Top module: `pkey_gate`

## Requirements
- R1: While reset is asserted, `chk_valid`, `key_fault` and `code_out` are all zero, and the gate mask is cleared.
- R2: Domain k occupies bits 2k (access-disable) and 2k+1 (write-disable) of a key register. The domain is read from `ukey_reg` when `page_user`=1 and from `skey_reg` when `page_user`=0.
- R3: No access ever faults unless `long_mode`=1 and at least one of `pke_user` and `pke_sup` is 1.
- R4: An access whose error code has the reserved bit (bit 3) or the fetch bit (bit 4) set never faults.
- R5: When the check applies, a set access-disable bit faults both reads and writes. Bit 1 of the error code is the write flag.
- R6: A set write-disable bit faults only a write that is a user access (error code bit 2) or that occurs while `wr_prot`=1.
- R7: A request on `req_valid` produces `chk_valid` one cycle later. `code_out[4:0]` carries that request's error code, and `code_out[5]` equals `key_fault`.
- R8: A change on a control input takes effect for requests one cycle later. A request presented in the same cycle as the change is judged with the previous controls.
- R9: Error code bit 0 (present) has no effect on the fault decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ukey_reg | input | 32 | Key register for user pages |
| skey_reg | input | 32 | Key register for supervisor pages |
| pke_user | input | 1 | Key checking enabled for user pages |
| pke_sup | input | 1 | Key checking enabled for supervisor pages |
| long_mode | input | 1 | Long mode active |
| wr_prot | input | 1 | Write-protect control |
| req_valid | input | 1 | Access request strobe |
| page_key | input | 4 | Protection key of the translated page |
| page_user | input | 1 | Page is a user page |
| err_in | input | 5 | Error code: present, write, user, reserved, fetch |
| chk_valid | output | 1 | Result strobe, one cycle after request |
| key_fault | output | 1 | Protection-key fault |
| code_out | output | 6 | Error code with key-fault bit 5 |

## Verification
The assertions assume that every input is a known value on each rising edge. They also assume that the key registers and the page key belong to the request presented in that same cycle, because the fault and no-fault properties look back one cycle at them. The stimulus changes every input only on the falling clock edge. Outside the one test of same-cycle control changes, it holds the controls steady for a full cycle before any request that is compared against the reference model, so the expected result always reflects a settled mask.

// File: rtl/pkey_gate.sv
`timescale 1ns/1ps
module pkey_gate #(
  parameter int KEY_W  = 4,
  parameter int ATTR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [(1<<KEY_W)*ATTR_W-1:0] ukey_reg,
  input  logic [(1<<KEY_W)*ATTR_W-1:0] skey_reg,
  input  logic                       pke_user,
  input  logic                       pke_sup,
  input  logic                       long_mode,
  input  logic                       wr_prot,
  input  logic                       req_valid,
  input  logic [KEY_W-1:0]           page_key,
  input  logic                       page_user,
  input  logic [4:0]                 err_in,
  output logic                       chk_valid,
  output logic                       key_fault,
  output logic [5:0]                 code_out
);
  localparam int NDOM  = 1 << KEY_W;
  localparam int REG_W = NDOM * ATTR_W;
  localparam int NIDX  = 16;
  localparam int MSK_W = NIDX * ATTR_W;

  logic [MSK_W-1:0] mask_q, mask_d;
  logic [REG_W-1:0] sel_reg;
  logic [1:0]       dom, ent;
  logic             hit, keys_on;

  assign keys_on = long_mode & (pke_user | pke_sup);

  always_comb begin
    mask_d = '0;
    for (int i = 0; i < NIDX; i++) begin
      logic w, u, r, f, chk;
      w   = i[0];
      u   = i[1];
      r   = i[2];
      f   = i[3];
      chk = keys_on & ~r & ~f;
      mask_d[2*i]   = chk;
      mask_d[2*i+1] = chk & w & (u | wr_prot);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;

  assign sel_reg = page_user ? ukey_reg : skey_reg;
  assign dom     = sel_reg[{page_key, 1'b0} +: 2];
  assign ent     = mask_q[{err_in[4:1], 1'b0} +: 2];
  assign hit     = |(dom & ent);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chk_valid <= 1'b0;
      key_fault <= 1'b0;
      code_out  <= '0;
    end else begin
      chk_valid <= req_valid;
      key_fault <= req_valid & hit;
      code_out  <= req_valid ? {hit, err_in} : '0;
    end

  a_r3_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(long_mode) && ($past(pke_user) || $past(pke_sup))) |-> mask_q == '0);

  a_r4_no_fault_rsvd_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && (code_out[3] || code_out[4])) |-> !key_fault);

  a_r6_read_needs_ad: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !err_in[1] && !dom[0]) |=> !key_fault);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> chk_valid);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!chk_valid && !key_fault));

  a_r7_code_pass: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> code_out[4:0] == $past(err_in));

  a_r7_flag_bit: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> code_out[5] == key_fault);
endmodule

// File: tb/pkey_gate_bench.sv
`timescale 1ns/1ps
module pkey_gate_bench;
  logic        clk = 0, rst_n = 0;
  logic [31:0] ukey_reg = 0, skey_reg = 0;
  logic        pke_user = 0, pke_sup = 0, long_mode = 0, wr_prot = 0;
  logic        req_valid = 0;
  logic [3:0]  page_key = 0;
  logic        page_user = 0;
  logic [4:0]  err_in = 0;
  logic        chk_valid, key_fault;
  logic [5:0]  code_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pkey_gate u_pkey_gate (
    .clk(clk), .rst_n(rst_n), .ukey_reg(ukey_reg), .skey_reg(skey_reg),
    .pke_user(pke_user), .pke_sup(pke_sup), .long_mode(long_mode),
    .wr_prot(wr_prot), .req_valid(req_valid), .page_key(page_key),
    .page_user(page_user), .err_in(err_in), .chk_valid(chk_valid),
    .key_fault(key_fault), .code_out(code_out));

  function automatic logic model(input logic [3:0] c, input logic [31:0] uk,
      input logic [31:0] sk, input logic [3:0] k, input logic pu, input logic [4:0] e);
    logic on, w, u, r, f, ad, wd;
    on = c[2] & (c[0] | c[1]);
    w = e[1]; u = e[2]; r = e[3]; f = e[4];
    ad = pu ? uk[2*k] : sk[2*k];
    wd = pu ? uk[2*k+1] : sk[2*k+1];
    if (!on || r || f) return 1'b0;
    return ad | (wd & w & (u | c[3]));
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic set_ctrl(input logic [3:0] c);
    pke_user = c[0]; pke_sup = c[1]; long_mode = c[2]; wr_prot = c[3];
  endtask

  task automatic one(input string tag, input logic [3:0] c, input logic [3:0] k,
      input logic pu, input logic [4:0] e);
    logic exp;
    req_valid = 1; page_key = k; page_user = pu; err_in = e;
    exp = model(c, ukey_reg, skey_reg, k, pu, e);
    @(negedge clk);
    req_valid = 0;
    chk(tag, chk_valid, 1);
    chk(tag, key_fault, exp);
    chk("R7", code_out, {exp, e});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", {chk_valid, key_fault, code_out}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {chk_valid, key_fault}, 0);

    // R2 directed: domain 5 AD in user reg only
    set_ctrl(4'b0111); ukey_reg = 32'h1 << 10; skey_reg = 0;
    @(negedge clk);
    one("R2", 4'b0111, 4'd5, 1'b1, 5'b00001);
    one("R2", 4'b0111, 4'd5, 1'b0, 5'b00001);
    one("R2", 4'b0111, 4'd4, 1'b1, 5'b00001);
    skey_reg = 32'h2 << 30;
    one("R2", 4'b0111, 4'd15, 1'b0, 5'b00011);
    one("R6", 4'b0111, 4'd15, 1'b0, 5'b00001);
    one("R9", 4'b0111, 4'd15, 1'b0, 5'b00010);

    // R8: change controls in the same cycle as a request
    set_ctrl(4'b0000); ukey_reg = '1; skey_reg = '1;
    @(negedge clk);
    set_ctrl(4'b0111);
    one("R8", 4'b0000, 4'd3, 1'b1, 5'b00011);
    one("R8", 4'b0111, 4'd3, 1'b1, 5'b00011);
    set_ctrl(4'b0000);
    one("R8", 4'b0111, 4'd3, 1'b1, 5'b00011);
    one("R3", 4'b0000, 4'd3, 1'b1, 5'b00011);

    // exhaustive sweep with random key registers
    for (int c = 0; c < 16; c++) begin
      set_ctrl(c[3:0]);
      @(negedge clk);
      for (int e = 0; e < 32; e++)
        for (int pu = 0; pu < 2; pu++)
          for (int k = 0; k < 16; k++) begin
            string tag;
            ukey_reg = $urandom; skey_reg = $urandom;
            if (!(c[2] && (c[0] || c[1]))) tag = "R3";
            else if (e[3] || e[4]) tag = "R4";
            else if (e[1]) tag = "R6";
            else tag = "R5";
            one(tag, c[3:0], k[3:0], pu[0], e[4:0]);
          end
    end

    // random gaps: idle cycles must stay quiet
    for (int i = 0; i < 200; i++) begin
      logic [3:0] c;
      c = $urandom; set_ctrl(c);
      ukey_reg = $urandom; skey_reg = $urandom;
      @(negedge clk);
      chk("R7", {chk_valid, key_fault}, 0);
      one("R5", c, 4'($urandom), 1'($urandom), 5'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule